// File: doc/BRIEF.md
# Port Access Decoder with Mailbox

This block sits at one port of a two-port, two-direction buffer. On every rising port clock it decodes the port's chip select, write/read select, enable and mailbox select into one of four operations: push a word into the outgoing FIFO, pop a word from the incoming FIFO, load the outgoing mailbox, or read the incoming mailbox. It also decides whether the shared data bus is an input, an output or high-impedance.

The block owns one 36-bit mailbox register that this port writes and the opposite port reads. An active-low full flag goes LOW when the register is loaded and returns HIGH when the opposite port reads it. The read strobe this port raises for the incoming mailbox is handed to the opposite port's instance, where it releases that mailbox's flag. The port's read data comes from a multiplexer that selects either the FIFO output register or the incoming mailbox. The FIFO storage and any clock-domain crossing of the flags are outside the block. Both ports are assumed to share one clock here.

Top module: `port_mail_decoder`

## Requirements
- R1: While `csN` is 1, all four operation strobes are 0 and both `busInEn` and `busOutEn` are 0, whatever `wrSel`, `en` and `mbSel` are.
- R2: While `csN` is 0, `busInEn` equals `wrSel` and `busOutEn` equals the inverse of `wrSel`, independently of `en`.
- R3: `csN`=0, `wrSel`=1, `en`=1, `mbSel`=0 raises `fifoWrStb` and no other strobe.
- R4: `csN`=0, `wrSel`=1, `en`=1, `mbSel`=1 raises `mailWrStb`. At that rising edge `mailboxOut` takes `dataIn` and `mailFullN` goes to 0.
- R5: `csN`=0, `wrSel`=0, `en`=1, `mbSel`=0 raises `fifoRdStb` and no other strobe.
- R6: `csN`=0, `wrSel`=0, `en`=1, `mbSel`=1 raises `mailRdStb` and no other strobe. This strobe is the release request for the opposite port's full flag.
- R7: With `en`=0 no strobe is raised, and `mailboxOut` and `mailFullN` keep their values across the edge unless `peerMailRead` is 1.
- R8: `peerMailRead`=1 at a rising edge without a mailbox write sets `mailFullN` to 1 and leaves `mailboxOut` unchanged.
- R9: If a mailbox write and `peerMailRead` occur at the same edge, the write wins: `mailFullN` is 0 and the new word is stored.
- R10: `dataOut` equals `inboxData` while `csN`=0, `wrSel`=0 and `mbSel`=1, whatever `en` is. Otherwise it equals `fifoOutData`.
- R11: While `rstN` is 0 (asynchronous, active low), `mailboxOut` is 0 and `mailFullN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| wrSel | input | 1 | 1 = write into block, 0 = read from block |
| en | input | 1 | Port enable, active high |
| mbSel | input | 1 | 1 = mailbox access, 0 = FIFO access |
| dataIn | input | 36 | Word arriving on the port bus |
| fifoOutData | input | 36 | Current FIFO output register |
| inboxData | input | 36 | Opposite port's mailbox register |
| peerMailRead | input | 1 | Opposite port reads this port's mailbox |
| fifoWrStb | output | 1 | FIFO push request |
| fifoRdStb | output | 1 | FIFO pop request |
| mailWrStb | output | 1 | Outgoing mailbox load |
| mailRdStb | output | 1 | Incoming mailbox read (releases peer flag) |
| busInEn | output | 1 | Bus is an input |
| busOutEn | output | 1 | Bus is driven by the block |
| dataOut | output | 36 | Read data mux output |
| mailboxOut | output | 36 | Outgoing mailbox register |
| mailFullN | output | 1 | Outgoing mailbox full, active low |

## Verification
The checker enforces on every cycle the idle behaviour when the chip is deselected, the bus direction and exclusivity, that at most one strobe is raised at a time, the read-mux selection, the load-and-flag effect of a mailbox write, the release by a peer read, and the register holding still when nothing touches it. The bench's scenarios are needed to show that every select combination maps to the right single operation. They also show that a write and a peer read on the same edge leave the flag LOW with the new word, that the reset values hold, and that several different data patterns pass through both register and mux intact.

// File: rtl/port_mail_pkg.sv
package port_mail_pkg;
  localparam int WORD_W = 36;

  typedef struct packed {
    logic fifoWr;
    logic fifoRd;
    logic mailWr;
    logic mailRd;
    logic busIn;
    logic busOut;
    logic showInbox;
  } portStrobes_t;
endpackage

// File: rtl/port_access_ctrl.sv
module port_access_ctrl
  import port_mail_pkg::*;
(
  input  logic         csN,
  input  logic         wrSel,
  input  logic         en,
  input  logic         mbSel,
  output portStrobes_t stb
);
  logic selected;
  logic active;

  always_comb begin
    selected      = ~csN;
    active        = selected & en;
    stb.busIn     = selected & wrSel;
    stb.busOut    = selected & ~wrSel;
    stb.fifoWr    = active & wrSel & ~mbSel;
    stb.mailWr    = active & wrSel & mbSel;
    stb.fifoRd    = active & ~wrSel & ~mbSel;
    stb.mailRd    = active & ~wrSel & mbSel;
    stb.showInbox = selected & ~wrSel & mbSel;
  end
endmodule

// File: rtl/port_mail_datapath.sv
module port_mail_datapath
  import port_mail_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  portStrobes_t  stb,
  input  logic          peerMailRead,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] fifoOutData,
  input  logic [DW-1:0] inboxData,
  output logic [DW-1:0] dataOut,
  output logic [DW-1:0] mailboxOut,
  output logic          mailFullN
);
  logic [DW-1:0] mailReg;
  logic          fullNReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mailReg  <= '0;
      fullNReg <= 1'b1;
    end else begin
      if (stb.mailWr) begin
        mailReg  <= dataIn;
        fullNReg <= 1'b0;
      end else if (peerMailRead) begin
        fullNReg <= 1'b1;
      end
    end
  end

  assign dataOut    = stb.showInbox ? inboxData : fifoOutData;
  assign mailboxOut = mailReg;
  assign mailFullN  = fullNReg;
endmodule

// File: rtl/port_mail_decoder.sv
module port_mail_decoder
  import port_mail_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          wrSel,
  input  logic          en,
  input  logic          mbSel,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] fifoOutData,
  input  logic [DW-1:0] inboxData,
  input  logic          peerMailRead,
  output logic          fifoWrStb,
  output logic          fifoRdStb,
  output logic          mailWrStb,
  output logic          mailRdStb,
  output logic          busInEn,
  output logic          busOutEn,
  output logic [DW-1:0] dataOut,
  output logic [DW-1:0] mailboxOut,
  output logic          mailFullN
);
  portStrobes_t stb;

  port_access_ctrl u_ctrl (
    .csN  (csN),
    .wrSel(wrSel),
    .en   (en),
    .mbSel(mbSel),
    .stb  (stb)
  );

  port_mail_datapath #(.DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .peerMailRead(peerMailRead),
    .dataIn      (dataIn),
    .fifoOutData (fifoOutData),
    .inboxData   (inboxData),
    .dataOut     (dataOut),
    .mailboxOut  (mailboxOut),
    .mailFullN   (mailFullN)
  );

  assign fifoWrStb = stb.fifoWr;
  assign fifoRdStb = stb.fifoRd;
  assign mailWrStb = stb.mailWr;
  assign mailRdStb = stb.mailRd;
  assign busInEn   = stb.busIn;
  assign busOutEn  = stb.busOut;
endmodule

// File: rtl/port_mail_checker.sv
module port_mail_checker #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rstN,
  input logic          csN,
  input logic          wrSel,
  input logic          en,
  input logic          mbSel,
  input logic [DW-1:0] dataIn,
  input logic [DW-1:0] inboxData,
  input logic          peerMailRead,
  input logic          fifoWrStb,
  input logic          fifoRdStb,
  input logic          mailWrStb,
  input logic          mailRdStb,
  input logic          busInEn,
  input logic          busOutEn,
  input logic [DW-1:0] dataOut,
  input logic [DW-1:0] mailboxOut,
  input logic          mailFullN
);
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !(fifoWrStb || fifoRdStb || mailWrStb || mailRdStb || busInEn || busOutEn));

  p_bus_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busInEn && busOutEn));

  p_write_needs_input_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrStb || mailWrStb) |-> busInEn);

  p_read_needs_output_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRdStb || mailRdStb) |-> busOutEn);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fifoWrStb, fifoRdStb, mailWrStb, mailRdStb}));

  p_no_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> !(fifoWrStb || fifoRdStb || mailWrStb || mailRdStb));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!mailWrStb && !peerMailRead) |=> ($stable(mailboxOut) && $stable(mailFullN)));

  p_mail_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    mailWrStb |=> (!mailFullN && mailboxOut == $past(dataIn)));

  p_peer_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (peerMailRead && !mailWrStb) |=> (mailFullN && $stable(mailboxOut)));

  p_inbox_mux_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busOutEn && mbSel) |-> dataOut == inboxData);
endmodule

bind port_mail_decoder port_mail_checker #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wrSel(wrSel), .en(en), .mbSel(mbSel),
  .dataIn(dataIn), .inboxData(inboxData), .peerMailRead(peerMailRead),
  .fifoWrStb(fifoWrStb), .fifoRdStb(fifoRdStb), .mailWrStb(mailWrStb),
  .mailRdStb(mailRdStb), .busInEn(busInEn), .busOutEn(busOutEn),
  .dataOut(dataOut), .mailboxOut(mailboxOut), .mailFullN(mailFullN)
);

// File: tb/sim_port_mail_decoder.sv
`timescale 1ns/1ps
module sim_port_mail_decoder;
  localparam int DW = 36;

  typedef struct {
    logic [3:0]    strobes;
    logic          bIn;
    logic          bOut;
    logic [DW-1:0] dOut;
    logic [DW-1:0] mbox;
    logic          fullN;
    string         req;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic csN = 1, wrSel = 0, en = 0, mbSel = 0, peerMailRead = 0;
  logic [DW-1:0] dataIn = '0, fifoOutData = '0, inboxData = '0;
  logic fifoWrStb, fifoRdStb, mailWrStb, mailRdStb, busInEn, busOutEn, mailFullN;
  logic [DW-1:0] dataOut, mailboxOut;

  int checks = 0;
  int errors = 0;
  expItem_t q[$];
  logic [DW-1:0] mdlMbox = '0;
  logic mdlFullN = 1'b1;
  bit driverDone = 0;

  always #4 clk = ~clk;

  port_mail_decoder u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .wrSel(wrSel), .en(en), .mbSel(mbSel),
    .dataIn(dataIn), .fifoOutData(fifoOutData), .inboxData(inboxData),
    .peerMailRead(peerMailRead), .fifoWrStb(fifoWrStb), .fifoRdStb(fifoRdStb),
    .mailWrStb(mailWrStb), .mailRdStb(mailRdStb), .busInEn(busInEn),
    .busOutEn(busOutEn), .dataOut(dataOut), .mailboxOut(mailboxOut),
    .mailFullN(mailFullN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outcome.
  task automatic step(input logic c, input logic w, input logic e, input logic m,
                      input logic [DW-1:0] din, input logic [DW-1:0] fo,
                      input logic [DW-1:0] ib, input logic pr, input string req);
    expItem_t it;
    logic sel, act;
    @(negedge clk);
    #1;
    csN = c; wrSel = w; en = e; mbSel = m;
    dataIn = din; fifoOutData = fo; inboxData = ib; peerMailRead = pr;
    sel = ~c;
    act = sel & e;
    it.strobes = {act & w & ~m, act & ~w & ~m, act & w & m, act & ~w & m};
    it.bIn  = sel & w;
    it.bOut = sel & ~w;
    it.dOut = (sel & ~w & m) ? ib : fo;
    if (act & w & m) begin
      mdlMbox  = din;
      mdlFullN = 1'b0;
    end else if (pr) begin
      mdlFullN = 1'b1;
    end
    it.mbox  = mdlMbox;
    it.fullN = mdlFullN;
    it.req   = req;
    q.push_back(it);
  endtask

  // Monitor: one negedge after the drive, the rising edge has passed.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        check({fifoWrStb, fifoRdStb, mailWrStb, mailRdStb} == it.strobes, it.req, "strobes",
              DW'({fifoWrStb, fifoRdStb, mailWrStb, mailRdStb}), DW'(it.strobes));
        check(busInEn == it.bIn && busOutEn == it.bOut, it.req, "bus enables",
              DW'({busInEn, busOutEn}), DW'({it.bIn, it.bOut}));
        check(dataOut == it.dOut, it.req, "dataOut", dataOut, it.dOut);
        check(mailboxOut == it.mbox, it.req, "mailboxOut", mailboxOut, it.mbox);
        check(mailFullN == it.fullN, it.req, "mailFullN", DW'(mailFullN), DW'(it.fullN));
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(mailboxOut == '0 && mailFullN == 1'b1, "R11", "reset state",
          DW'({mailFullN, mailboxOut[3:0]}), DW'(5'h10));
    @(negedge clk);
    rstN = 1;

    // R1: deselected, every select combination
    for (int k = 0; k < 16; k++)
      step(1'b1, k[0], k[1], k[2], 36'hA5A5A5A5A, 36'h111111111, 36'h222222222, 1'b0, "R1");
    // R2 / R10: selected but disabled, each direction and mux choice
    step(0, 1, 0, 0, 36'h1, 36'h0F0F0F0F0, 36'h3C3C3C3C3, 0, "R2");
    step(0, 0, 0, 0, 36'h1, 36'h0F0F0F0F0, 36'h3C3C3C3C3, 0, "R2");
    step(0, 0, 0, 1, 36'h1, 36'h0F0F0F0F0, 36'h3C3C3C3C3, 0, "R10");
    // R7: write mailbox selects without enable leave the register alone
    step(0, 1, 0, 1, 36'hDEADBEEF0, 36'h0, 36'h0, 0, "R7");
    // R3 FIFO write, R5 FIFO read
    step(0, 1, 1, 0, 36'h123456789, 36'h0, 36'h0, 0, "R3");
    step(0, 0, 1, 0, 36'h0, 36'h987654321, 36'hFFFFFFFFF, 0, "R5");
    // R4 mailbox write, then hold
    step(0, 1, 1, 1, 36'hCAFEF00D5, 36'h0, 36'h0, 0, "R4");
    step(1, 0, 0, 0, 36'h0, 36'h0, 36'h0, 0, "R7");
    // R6 mailbox read of incoming mailbox, with R10 mux
    step(0, 0, 1, 1, 36'h0, 36'h555555555, 36'hAAAAAAAAA, 0, "R6");
    // R8 peer release
    step(1, 0, 0, 0, 36'h0, 36'h0, 36'h0, 1, "R8");
    step(0, 1, 1, 0, 36'h777777777, 36'h0, 36'h0, 0, "R3");
    // R9 write and peer read on the same edge
    step(0, 1, 1, 1, 36'h800000001, 36'h0, 36'h0, 1, "R9");
    step(0, 0, 0, 0, 36'h0, 36'h0, 36'h0, 0, "R7");
    // R4 overwrite while still full, R8 release from disabled read
    step(0, 1, 1, 1, 36'hFFFFFFFFF, 36'h0, 36'h0, 0, "R4");
    step(0, 0, 0, 1, 36'h0, 36'h0, 36'h0F00F00F0, 1, "R8");
    step(1, 1, 1, 1, 36'h0, 36'h0, 36'h0, 0, "R1");

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule